// File: doc/BRIEF.md
# Reader Pin-Mode and Output Routing Logic

This block sits between the configuration register of a low-frequency RFID reader front end and its two digital pins. It decides what the serial output pin shows and whether the serial input pin keys the antenna driver. The configuration bits, a strap level and the active clock source together select the mode. In one mode the input and output pins can be wired together as a two-wire half-duplex link. In another, the output pin carries either the demodulated transponder data or a monitor clock that is the carrier divided by 32. The block also divides an external 4 MHz-class clock by 32 to form the carrier, latches the antenna short-circuit fault, and hides the lock flag when the carrier comes from the external clock.

A small state machine with four states tracks the pin ownership. The states are SLEEP, RUN, FAULT and CMD. Its transitions are:
- SLEEP→RUN when the active bit is set and no fault is stored.
- SLEEP→FAULT when the active bit is set and a fault is stored.
- RUN→FAULT on a short-circuit detect.
- RUN/FAULT→SLEEP when the active bit is cleared.
- any→CMD while the serial interface owns the pins.
- CMD→SLEEP, FAULT or RUN when the command phase ends. The choice depends on the active bit and the fault latch.

Top module: `rdr_pin_router`

## Requirements
- R1: Half-duplex mode applies when cfg_ext_clk=0, ec_pin=1 and cfg_dir_sel=0. In it, out_pin follows demod_cmp in RUN and drv_en is 1 whatever in_pin does.
- R2: With cfg_ext_clk=0, ec_pin=1 and cfg_dir_sel=1, drv_en follows in_pin in RUN (1 = driver on, 0 = off) and out_pin is 0.
- R3: With cfg_ext_clk=0 and ec_pin=0, drv_en is 1 in RUN. out_pin shows demod_cmp when cfg_dir_sel=0 and the monitor clock when cfg_dir_sel=1.
- R4: With cfg_ext_clk=1, out_pin selection is as in R3 whatever ec_pin is, and drv_en is 1 in RUN. The carrier is then ec_pin divided by 32, and its first rising edge follows the 16th ec_pin rising edge.
- R5: The monitor clock is the carrier divided by 32 with 50% duty. It goes high after the 16th carrier rising edge, low after the 32nd, and its counter is cleared in SLEEP.
- R6: A short_det pulse forces drv_en to 0 in the same cycle. sc_status then reads 1 and the driver stays off until cmd_done is seen.
- R7: lock_status equals pll_locked when cfg_ext_clk=0 and is 0 when cfg_ext_clk=1.
- R8: gain_idx decodes cfg_gain as {halve, double}, with gain = 120 << gain_idx: 00→2 (480), 01→3 (960), 11→1 (240), 10→0 (120).
- R9: When cfg_active=0 outside a command, the block enters SLEEP with out_pin=0 and drv_en=0.
- R10: While cmd_phase=1 (CMD), out_pin carries cmd_status_bit. in_pin does not key the driver, so drv_en is 1 when active and no fault is stored.
- R11: After reset the block is in SLEEP with out_pin=0, drv_en=0 and sc_status=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_active | input | 1 | Configuration active bit (0 = sleep) |
| cfg_dir_sel | input | 1 | Direction / data-clock select bit |
| cfg_ext_clk | input | 1 | Carrier source: 0 internal loop, 1 external clock |
| cfg_gain | input | 2 | {halve, double} gain bits |
| ec_pin | input | 1 | Strap level, or the external clock when cfg_ext_clk=1 |
| demod_cmp | input | 1 | Demodulator comparator output |
| pll_carrier | input | 1 | Internal loop carrier, sampled |
| pll_locked | input | 1 | Internal loop lock flag |
| in_pin | input | 1 | Serial input / keying pin |
| short_det | input | 1 | Antenna short-circuit detect pulse |
| cmd_phase | input | 1 | Serial interface owns the pins |
| cmd_done | input | 1 | New configuration loaded |
| cmd_status_bit | input | 1 | Status bit to drive during a command |
| out_pin | output | 1 | Serial output pin value |
| drv_en | output | 1 | Antenna driver enable |
| gain_idx | output | 2 | Amplifier gain index |
| sc_status | output | 1 | Latched short-circuit status |
| lock_status | output | 1 | Reported lock status |

## Verification
The assertions rely on four properties of the inputs:
- short_det and cmd_done are single-level strobes sampled on clk.
- cmd_phase and cfg_active change only between clock edges.
- pll_carrier and ec_pin are slow compared with clk, so every high and low phase lasts at least one cycle.
- cmd_done arrives only during a command phase.

The stimulus respects these properties. It changes every input at the falling edge and holds each carrier or strap level for a full clock cycle. It raises cmd_done only while cmd_phase is high. It issues short_det as a one-cycle strobe from RUN.

// File: rtl/rdr_pin_pkg.sv
package rdr_pin_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2,
        ST_CMD   = 2'd3
    } pin_state_t;

    typedef enum logic [1:0] {
        MD_HALF_DUPLEX = 2'd0,
        MD_MON_STRAP   = 2'd1,
        MD_MON_EXTCLK  = 2'd2
    } pin_mode_t;

    localparam int unsigned GAIN_W = 2;
endpackage

// File: rtl/rdr_edge_div.sv
module rdr_edge_div #(
    parameter int unsigned DIV_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic div_out
);
    localparam int unsigned CW = DIV_LOG2;

    logic [CW-1:0] cnt_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= tick_in;
            if (clr) begin
                cnt_q <= '0;
            end else if (tick_in && !prev_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign div_out = cnt_q[CW-1];

    // R5: counter cleared while held in sleep
    a_r5_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !div_out);
endmodule

// File: rtl/rdr_out_route.sv
module rdr_out_route
    import rdr_pin_pkg::*;
(
    input  logic              cfg_dir_sel,
    input  logic              cfg_ext_clk,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              ec_pin,
    input  logic              demod_cmp,
    input  logic              ref_clk,
    input  logic              in_pin,
    output logic              run_out,
    output logic              run_drv,
    output logic [GAIN_W-1:0] gain_idx
);
    pin_mode_t mode;

    always_comb begin
        if (cfg_ext_clk)      mode = MD_MON_EXTCLK;
        else if (ec_pin)      mode = MD_HALF_DUPLEX;
        else                  mode = MD_MON_STRAP;
    end

    always_comb begin
        run_out = 1'b0;
        run_drv = 1'b1;
        unique case (mode)
            MD_HALF_DUPLEX: begin
                run_out = cfg_dir_sel ? 1'b0 : demod_cmp;
                run_drv = cfg_dir_sel ? in_pin : 1'b1;
            end
            MD_MON_STRAP, MD_MON_EXTCLK: begin
                run_out = cfg_dir_sel ? ref_clk : demod_cmp;
                run_drv = 1'b1;
            end
            default: begin
                run_out = 1'b0;
                run_drv = 1'b0;
            end
        endcase
    end

    // {halve, double}: 00->480, 01->960, 11->240, 10->120 (gain = 120 << idx)
    always_comb begin
        unique case (cfg_gain)
            2'b00:   gain_idx = 2'd2;
            2'b01:   gain_idx = 2'd3;
            2'b11:   gain_idx = 2'd1;
            default: gain_idx = 2'd0;
        endcase
    end
endmodule

// File: rtl/rdr_pin_router.sv
module rdr_pin_router
    import rdr_pin_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_active,
    input  logic              cfg_dir_sel,
    input  logic              cfg_ext_clk,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              ec_pin,
    input  logic              demod_cmp,
    input  logic              pll_carrier,
    input  logic              pll_locked,
    input  logic              in_pin,
    input  logic              short_det,
    input  logic              cmd_phase,
    input  logic              cmd_done,
    input  logic              cmd_status_bit,
    output logic              out_pin,
    output logic              drv_en,
    output logic [GAIN_W-1:0] gain_idx,
    output logic              sc_status,
    output logic              lock_status
);
    pin_state_t state_q, state_d;
    logic       fault_q, fault_d;
    logic       ext_carrier, carrier, ref_clk;
    logic       run_out, run_drv, div_clr;

    assign div_clr = (state_q == ST_SLEEP);
    assign fault_d = short_det | (fault_q & ~cmd_done);

    rdr_edge_div #(.DIV_LOG2(DIV_LOG2)) u_ext_div (
        .clk(clk), .rst_n(rst_n), .clr(div_clr),
        .tick_in(ec_pin), .div_out(ext_carrier)
    );

    assign carrier = cfg_ext_clk ? ext_carrier : pll_carrier;

    rdr_edge_div #(.DIV_LOG2(DIV_LOG2)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .clr(div_clr),
        .tick_in(carrier), .div_out(ref_clk)
    );

    rdr_out_route u_route (
        .cfg_dir_sel(cfg_dir_sel), .cfg_ext_clk(cfg_ext_clk),
        .cfg_gain(cfg_gain), .ec_pin(ec_pin), .demod_cmp(demod_cmp),
        .ref_clk(ref_clk), .in_pin(in_pin),
        .run_out(run_out), .run_drv(run_drv), .gain_idx(gain_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            fault_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (cmd_phase)       state_d = ST_CMD;
                else if (cfg_active) state_d = fault_d ? ST_FAULT : ST_RUN;
            end
            ST_RUN: begin
                if (cmd_phase)        state_d = ST_CMD;
                else if (!cfg_active) state_d = ST_SLEEP;
                else if (fault_d)     state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (cmd_phase)        state_d = ST_CMD;
                else if (!cfg_active) state_d = ST_SLEEP;
            end
            ST_CMD: begin
                if (!cmd_phase) begin
                    if (!cfg_active)  state_d = ST_SLEEP;
                    else if (fault_d) state_d = ST_FAULT;
                    else              state_d = ST_RUN;
                end
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    // outputs
    always_comb begin
        out_pin = 1'b0;
        drv_en  = 1'b0;
        unique case (state_q)
            ST_SLEEP: begin
                out_pin = 1'b0;
                drv_en  = 1'b0;
            end
            ST_RUN: begin
                out_pin = run_out;
                drv_en  = run_drv & ~short_det;
            end
            ST_FAULT: begin
                out_pin = run_out;
                drv_en  = 1'b0;
            end
            ST_CMD: begin
                out_pin = cmd_status_bit;
                drv_en  = cfg_active & ~fault_q & ~short_det;
            end
            default: begin
                out_pin = 1'b0;
                drv_en  = 1'b0;
            end
        endcase
    end

    assign sc_status   = fault_q;
    assign lock_status = pll_locked & ~cfg_ext_clk;

    // assertions
    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |-> (!drv_en && !out_pin));
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_status && !cmd_done) |=> sc_status);
    a_r6_short_off: assert property (@(posedge clk) disable iff (!rst_n)
        short_det |-> !drv_en);
    a_r7_ext_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext_clk |-> !lock_status);
    a_r10_cmd_no_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD && cfg_active && !sc_status && !short_det) |-> drv_en);
    a_r2_half_duplex_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cfg_ext_clk && ec_pin && cfg_dir_sel) |-> !out_pin);
endmodule

// File: tb/rdr_pin_router_tb.sv
`timescale 1ns/1ps
module rdr_pin_router_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_active = 0, cfg_dir_sel = 0, cfg_ext_clk = 0;
    logic [1:0] cfg_gain = 2'b00;
    logic ec_pin = 0, demod_cmp = 0, pll_carrier = 0, pll_locked = 1;
    logic in_pin = 0, short_det = 0, cmd_phase = 0, cmd_done = 0, cmd_status_bit = 0;
    logic out_pin, drv_en, sc_status, lock_status;
    logic [1:0] gain_idx;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic       o;
        logic       d;
        logic       sc;
        logic       lk;
        logic [1:0] g;
        string      req;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    rdr_pin_router dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_active(cfg_active), .cfg_dir_sel(cfg_dir_sel),
        .cfg_ext_clk(cfg_ext_clk), .cfg_gain(cfg_gain), .ec_pin(ec_pin),
        .demod_cmp(demod_cmp), .pll_carrier(pll_carrier), .pll_locked(pll_locked),
        .in_pin(in_pin), .short_det(short_det), .cmd_phase(cmd_phase),
        .cmd_done(cmd_done), .cmd_status_bit(cmd_status_bit),
        .out_pin(out_pin), .drv_en(drv_en), .gain_idx(gain_idx),
        .sc_status(sc_status), .lock_status(lock_status)
    );

    task automatic compare(input exp_t e);
        n_cmp++;
        if (out_pin !== e.o || drv_en !== e.d || sc_status !== e.sc ||
            lock_status !== e.lk || gain_idx !== e.g) begin
            n_bad++;
            $display("FAIL %s: actual out=%b drv=%b sc=%b lock=%b gain=%0d expected out=%b drv=%b sc=%b lock=%b gain=%0d",
                     e.req, out_pin, drv_en, sc_status, lock_status, gain_idx,
                     e.o, e.d, e.sc, e.lk, e.g);
        end
    endtask

    // monitor: pops expectations after each rising edge settles
    always begin
        @(posedge clk);
        #2;
        while (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    // driver: waits one edge, queues expectation, returns at falling edge
    task automatic expect_after(input logic o, input logic d, input logic sc,
                                input logic lk, input logic [1:0] g, input string req);
        exp_t e;
        e.o = o; e.d = d; e.sc = sc; e.lk = lk; e.g = g; e.req = req;
        @(posedge clk);
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic pulse_carrier(input int n);
        for (int i = 0; i < n; i++) begin
            pll_carrier = 1'b1; @(posedge clk); @(negedge clk);
            pll_carrier = 1'b0; @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic pulse_ec(input int n);
        for (int i = 0; i < n; i++) begin
            ec_pin = 1'b1; @(posedge clk); @(negedge clk);
            ec_pin = 1'b0; @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        exp_t now_e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_after(0, 0, 0, 1, 2, "R11 reset state");

        // half-duplex mode, receive direction
        cfg_active = 1; ec_pin = 1; demod_cmp = 1; in_pin = 0;
        expect_after(1, 1, 0, 1, 2, "R1 data out, driver on with in low");
        demod_cmp = 0; in_pin = 1;
        expect_after(0, 1, 0, 1, 2, "R1 data low");
        // half-duplex, transmit direction
        cfg_dir_sel = 1; demod_cmp = 1;
        expect_after(0, 1, 0, 1, 2, "R2 in high keys on, out low");
        in_pin = 0;
        expect_after(0, 0, 0, 1, 2, "R2 in low keys off");

        // monitor mode with strap low
        ec_pin = 0; cfg_dir_sel = 0;
        expect_after(1, 1, 0, 1, 2, "R3 demod routed");
        cfg_dir_sel = 1;
        expect_after(0, 1, 0, 1, 2, "R3 ref routed, in ignored");

        // sleep clears dividers
        cfg_active = 0; in_pin = 1;
        expect_after(0, 0, 0, 1, 2, "R9 sleep quiet");
        cfg_active = 1; in_pin = 0;
        expect_after(0, 1, 0, 1, 2, "R3 wake");
        pulse_carrier(15);
        expect_after(0, 1, 0, 1, 2, "R5 ref low after 15 edges");
        pulse_carrier(1);
        expect_after(1, 1, 0, 1, 2, "R5 ref high after 16 edges");
        pulse_carrier(15);
        expect_after(1, 1, 0, 1, 2, "R5 ref high after 31 edges");
        pulse_carrier(1);
        expect_after(0, 1, 0, 1, 2, "R5 ref low after 32 edges");
        pulse_carrier(10);
        cfg_active = 0;
        expect_after(0, 0, 0, 1, 2, "R9 sleep mid-count");
        cfg_active = 1;
        expect_after(0, 1, 0, 1, 2, "R5 wake");
        pulse_carrier(10);
        expect_after(0, 1, 0, 1, 2, "R5 counter cleared by sleep");

        // external clock mode
        cfg_ext_clk = 1; cfg_dir_sel = 0; ec_pin = 1; demod_cmp = 1;
        expect_after(1, 1, 0, 0, 2, "R4 strap ignored, R7 lock hidden");
        ec_pin = 0; cfg_active = 0;
        expect_after(0, 0, 0, 0, 2, "R9 sleep");
        cfg_active = 1; cfg_dir_sel = 1;
        expect_after(0, 1, 0, 0, 2, "R4 wake ext");
        pulse_ec(495);
        expect_after(0, 1, 0, 0, 2, "R4 ref low after 495 ec edges");
        pulse_ec(1);
        expect_after(1, 1, 0, 0, 2, "R4 ref high after 496 ec edges");

        // back to internal loop, gain
        cfg_ext_clk = 0; cfg_dir_sel = 0; demod_cmp = 0;
        expect_after(0, 1, 0, 1, 2, "R7 lock shown");
        pll_locked = 0;
        expect_after(0, 1, 0, 0, 2, "R7 lock follows");
        pll_locked = 1; cfg_gain = 2'b01;
        expect_after(0, 1, 0, 1, 3, "R8 gain 960");
        cfg_gain = 2'b11;
        expect_after(0, 1, 0, 1, 1, "R8 gain 240");
        cfg_gain = 2'b10;
        expect_after(0, 1, 0, 1, 0, "R8 gain 120");
        cfg_gain = 2'b00;
        in_pin = 1;
        expect_after(0, 1, 0, 1, 2, "R8 gain 480");

        // short circuit
        short_det = 1;
        #1;
        now_e.o = 0; now_e.d = 0; now_e.sc = 0; now_e.lk = 1; now_e.g = 2;
        now_e.req = "R6 driver off same cycle";
        compare(now_e);
        expect_after(0, 0, 1, 1, 2, "R6 status set");
        short_det = 0;
        expect_after(0, 0, 1, 1, 2, "R6 status held");
        expect_after(0, 0, 1, 1, 2, "R6 status held 2");

        // command phase
        cmd_phase = 1; cmd_status_bit = 1; in_pin = 0;
        expect_after(1, 0, 1, 1, 2, "R10 status on out, R6 still off");
        cmd_done = 1;
        expect_after(1, 1, 0, 1, 2, "R6 cleared by command, R10 in not gating");
        cmd_done = 0; cmd_status_bit = 0; ec_pin = 1; cfg_dir_sel = 1;
        expect_after(0, 1, 0, 1, 2, "R10 no gating in half-duplex");
        cmd_phase = 0;
        expect_after(0, 0, 0, 1, 2, "R2 after command in gates");

        cfg_active = 0; ec_pin = 0; cfg_dir_sel = 0; demod_cmp = 1; in_pin = 1;
        expect_after(0, 0, 0, 1, 2, "R9 sleep with data present");

        @(posedge clk); #3;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule